// File: doc/BRIEF.md
# Miss Bus Command Selector

This block decides what a cache sends toward memory for a pending miss. It takes the kind of the original request, whether that request is uncacheable, whether it needs an exclusive copy, and the present state of the matching line. From these it picks one of three outcomes. The first is a fill command (plain read, exclusive read or upgrade) that always asks for a whole block. The second is a pass-through that sends the original request onward unchanged and leaves the cache untouched. The third is an error flag for combinations that must never reach it.

The decision is made by combinational logic and held in one output register. A result presented with `in_valid` appears on the outputs one clock later, qualified by `out_valid`. Alongside the command, the block also gives the response kind the cache should expect back, so the response path can be checked against what was asked for.

Top module: `miss_cmd_select`

## Requirements
- R1: While `rst` is high and in the cycle after, `out_valid`, `out_fill`, `out_err` are 0, `out_cmd` is 0 (none), `out_rsp` is 0 (none) and `out_len` is 0.
- R2: `out_valid` rises exactly one clock after a cycle with `in_valid` high and is low after a cycle with `in_valid` low. The other outputs keep their last value while `in_valid` is low.
- R3: An uncacheable request with line state 0 (invalid) gives `out_cmd` 4 (pass), `out_fill` 0, `out_rsp` 0 and `out_len` equal to `in_bytes`, for every request kind.
- R4: An uncacheable request with line state 1 (shared) or 2 (writable) sets `out_err`.
- R5: A cacheable request of kind 3 (writeback) or 4 (upgrade) with line state 0 gives `out_cmd` 4 (pass), `out_fill` 0 and `out_len` equal to `in_bytes`.
- R6: A cacheable request with line state 1 (shared) and `in_excl` high gives `out_cmd` 3 (upgrade), `out_fill` 1 and `out_rsp` 3 (upgrade response), whatever the request kind.
- R7: A cacheable request with line state 2 (writable), or with state 1 and `in_excl` low, sets `out_err`.
- R8: A cacheable request of kind 0 (read), 1 (write), 2 (read-exclusive) or 5 (swap) with line state 0 and `in_excl` high gives `out_cmd` 2 (read-exclusive), `out_fill` 1 and `out_rsp` 2 (read-exclusive response).
- R9: The same kinds with line state 0 and `in_excl` low give `out_cmd` 1 (read), `out_fill` 1 and `out_rsp` 1 (read response).
- R10: `out_fill` is 1 exactly when `out_cmd` is 1, 2 or 3, and then `out_len` equals BLOCK_BYTES (default 64).
- R11: A request kind of 6 or 7, or a line state of 3, sets `out_err`.
- R12: When `out_err` is 1, `out_cmd`, `out_fill`, `out_rsp` and `out_len` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request fields are valid this cycle |
| in_kind | input | 3 | Request kind: 0 read, 1 write, 2 read-exclusive, 3 writeback, 4 upgrade, 5 swap |
| in_uncache | input | 1 | Request bypasses the cache |
| in_excl | input | 1 | Request needs an exclusive copy |
| in_state | input | 2 | Line state: 0 invalid, 1 shared, 2 writable |
| in_bytes | input | LEN_W (7) | Byte size of the original request |
| out_valid | output | 1 | Result valid |
| out_cmd | output | 3 | Bus command: 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 pass |
| out_fill | output | 1 | Command fills the cache |
| out_len | output | LEN_W (7) | Bytes requested on the bus |
| out_rsp | output | 2 | Expected response: 0 none, 1 read, 2 read-exclusive, 3 upgrade |
| out_err | output | 1 | Illegal input combination |

## Verification
The hardest case to reach is the set of illegal combinations. These are a writable line, a shared line without an exclusive need, a valid line under an uncacheable request, and undefined encodings. A working cache never produces them, so the bench drives the raw fields directly. In each such case it checks that every output is zeroed, not only the error flag. It also makes sure that an error result does not leak into the held outputs seen during the following idle cycles.

// File: rtl/miss_cmd_pkg.sv
package miss_cmd_pkg;

  typedef enum logic [2:0] {
    K_READ    = 3'd0,
    K_WRITE   = 3'd1,
    K_READ_EX = 3'd2,
    K_WBACK   = 3'd3,
    K_UPGRADE = 3'd4,
    K_SWAP    = 3'd5
  } req_kind_e;

  typedef enum logic [1:0] {
    L_INVALID  = 2'd0,
    L_SHARED   = 2'd1,
    L_WRITABLE = 2'd2
  } line_state_e;

  typedef enum logic [2:0] {
    C_NONE    = 3'd0,
    C_READ    = 3'd1,
    C_READ_EX = 3'd2,
    C_UPGRADE = 3'd3,
    C_PASS    = 3'd4
  } bus_cmd_e;

  typedef enum logic [1:0] {
    RS_NONE    = 2'd0,
    RS_READ    = 2'd1,
    RS_READ_EX = 2'd2,
    RS_UPGRADE = 2'd3
  } rsp_kind_e;

  localparam int unsigned KIND_LAST = 5;

endpackage

// File: rtl/miss_cmd_classify.sv
module miss_cmd_classify
  import miss_cmd_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       uncache,
  input  logic       excl,
  input  logic [1:0] state,
  output logic [2:0] cmd,
  output logic       err
);

  logic kind_ok;
  logic state_ok;
  logic line_valid;
  logic bypass_kind;

  assign kind_ok     = (kind <= 3'(KIND_LAST));
  assign state_ok    = (state != 2'd3);
  assign line_valid  = (state != 2'(L_INVALID));
  assign bypass_kind = (kind == 3'(K_WBACK)) || (kind == 3'(K_UPGRADE));

  always_comb begin
    cmd = 3'(C_NONE);
    err = 1'b0;
    if (!kind_ok || !state_ok) begin
      err = 1'b1;
    end else if (uncache) begin
      if (line_valid) err = 1'b1;
      else            cmd = 3'(C_PASS);
    end else if (line_valid) begin
      if (excl && state == 2'(L_SHARED)) cmd = 3'(C_UPGRADE);
      else                               err = 1'b1;
    end else if (bypass_kind) begin
      cmd = 3'(C_PASS);
    end else begin
      cmd = excl ? 3'(C_READ_EX) : 3'(C_READ);
    end
  end

endmodule

// File: rtl/miss_cmd_rsp_map.sv
module miss_cmd_rsp_map
  import miss_cmd_pkg::*;
(
  input  logic [2:0] cmd,
  output logic [1:0] rsp,
  output logic       fill
);

  always_comb begin
    unique case (cmd)
      3'(C_READ):    rsp = 2'(RS_READ);
      3'(C_READ_EX): rsp = 2'(RS_READ_EX);
      3'(C_UPGRADE): rsp = 2'(RS_UPGRADE);
      default:       rsp = 2'(RS_NONE);
    endcase
  end

  assign fill = (cmd == 3'(C_READ)) || (cmd == 3'(C_READ_EX)) ||
                (cmd == 3'(C_UPGRADE));

endmodule

// File: rtl/miss_cmd_out_reg.sv
module miss_cmd_out_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic             valid,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      q     <= '0;
    end else begin
      valid <= load;
      if (load) q <= d;
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !load |=> (!valid && $stable(q)));

endmodule

// File: rtl/miss_cmd_select.sv
module miss_cmd_select
  import miss_cmd_pkg::*;
#(
  parameter int unsigned BLOCK_BYTES = 64,
  localparam int unsigned LEN_W = $clog2(BLOCK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       in_kind,
  input  logic             in_uncache,
  input  logic             in_excl,
  input  logic [1:0]       in_state,
  input  logic [LEN_W-1:0] in_bytes,
  output logic             out_valid,
  output logic [2:0]       out_cmd,
  output logic             out_fill,
  output logic [LEN_W-1:0] out_len,
  output logic [1:0]       out_rsp,
  output logic             out_err
);

  localparam int unsigned PACK_W = 3 + 1 + LEN_W + 2 + 1;

  logic [2:0]       dec_cmd;
  logic             dec_err;
  logic [1:0]       dec_rsp;
  logic             dec_fill;
  logic [LEN_W-1:0] dec_len;
  logic [PACK_W-1:0] pack_d;
  logic [PACK_W-1:0] pack_q;

  miss_cmd_classify u_classify (
    .kind    (in_kind),
    .uncache (in_uncache),
    .excl    (in_excl),
    .state   (in_state),
    .cmd     (dec_cmd),
    .err     (dec_err)
  );

  miss_cmd_rsp_map u_rsp (
    .cmd  (dec_cmd),
    .rsp  (dec_rsp),
    .fill (dec_fill)
  );

  always_comb begin
    if (dec_fill)                   dec_len = LEN_W'(BLOCK_BYTES);
    else if (dec_cmd == 3'(C_PASS)) dec_len = in_bytes;
    else                            dec_len = '0;
  end

  assign pack_d = {dec_cmd, dec_fill, dec_len, dec_rsp, dec_err};

  miss_cmd_out_reg #(.WIDTH(PACK_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .load  (in_valid),
    .d     (pack_d),
    .valid (out_valid),
    .q     (pack_q)
  );

  assign {out_cmd, out_fill, out_len, out_rsp, out_err} = pack_q;

  p_fill_len_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fill) |-> (out_len == LEN_W'(BLOCK_BYTES)));
  p_err_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_cmd == 3'(C_NONE) && !out_fill &&
                                out_rsp == 2'(RS_NONE) && out_len == '0));
  p_upg_src_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cmd == 3'(C_UPGRADE)) |->
      ($past(in_state) == 2'(L_SHARED) && $past(in_excl) && !$past(in_uncache)));
  p_pass_nofill_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cmd == 3'(C_PASS)) |->
      (!out_fill && $past(in_state) == 2'(L_INVALID)));
  p_rsp_match_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cmd == 3'(C_READ_EX)) |-> (out_rsp == 2'(RS_READ_EX) && $past(in_excl)));

endmodule

// File: tb/miss_cmd_select_tb.sv
module miss_cmd_select_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BLK = 64;
  localparam int LW  = $clog2(BLK + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_kind = '0;
  logic          in_uncache = 1'b0;
  logic          in_excl = 1'b0;
  logic [1:0]    in_state = '0;
  logic [LW-1:0] in_bytes = '0;
  logic          out_valid;
  logic [2:0]    out_cmd;
  logic          out_fill;
  logic [LW-1:0] out_len;
  logic [1:0]    out_rsp;
  logic          out_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  miss_cmd_select #(.BLOCK_BYTES(BLK)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_uncache(in_uncache), .in_excl(in_excl), .in_state(in_state),
    .in_bytes(in_bytes), .out_valid(out_valid), .out_cmd(out_cmd),
    .out_fill(out_fill), .out_len(out_len), .out_rsp(out_rsp), .out_err(out_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int kind, input bit unc, input bit ex,
                       input int st, input int bytes);
    @(negedge clk);
    in_valid = 1'b1; in_kind = 3'(kind); in_uncache = unc;
    in_excl = ex; in_state = 2'(st); in_bytes = LW'(bytes);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input int cmd, input int fill,
                            input int len, input int rsp, input int err);
    chk({tag, " valid"}, int'(out_valid), 1);
    chk({tag, " cmd"},   int'(out_cmd), cmd);
    chk({tag, " fill"},  int'(out_fill), fill);
    chk({tag, " len"},   int'(out_len), len);
    chk({tag, " rsp"},   int'(out_rsp), rsp);
    chk({tag, " err"},   int'(out_err), err);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 cmd", int'(out_cmd), 0);
    chk("R1 fill", int'(out_fill), 0);
    chk("R1 err", int'(out_err), 0);
    chk("R1 len", int'(out_len), 0);
    chk("R1 rsp", int'(out_rsp), 0);
  endtask

  task automatic t_uncache();
    for (int k = 0; k < 6; k++) begin
      apply(k, 1'b1, k[0], 0, 8 + k);
      expect_out("R3 uncache pass", 4, 0, 8 + k, 0, 0);
    end
    apply(0, 1'b1, 1'b0, 1, 4);
    expect_out("R4 uncache shared", 0, 0, 0, 0, 1);
    apply(1, 1'b1, 1'b1, 2, 4);
    expect_out("R4 uncache writable", 0, 0, 0, 0, 1);
  endtask

  task automatic t_bypass();
    apply(3, 1'b0, 1'b0, 0, 64);
    expect_out("R5 writeback miss", 4, 0, 64, 0, 0);
    apply(4, 1'b0, 1'b1, 0, 16);
    expect_out("R5 upgrade miss", 4, 0, 16, 0, 0);
  endtask

  task automatic t_upgrade();
    apply(1, 1'b0, 1'b1, 1, 4);
    expect_out("R6 write on shared", 3, 1, BLK, 3, 0);
    apply(5, 1'b0, 1'b1, 1, 8);
    expect_out("R6 swap on shared", 3, 1, BLK, 3, 0);
    apply(4, 1'b0, 1'b1, 1, 8);
    expect_out("R6 upgrade on shared", 3, 1, BLK, 3, 0);
  endtask

  task automatic t_fills();
    apply(2, 1'b0, 1'b1, 0, 4);
    expect_out("R8 readex invalid", 2, 1, BLK, 2, 0);
    apply(1, 1'b0, 1'b1, 0, 2);
    expect_out("R8 write invalid", 2, 1, BLK, 2, 0);
    apply(0, 1'b0, 1'b0, 0, 4);
    expect_out("R9 read invalid", 1, 1, BLK, 1, 0);
    apply(5, 1'b0, 1'b0, 0, 8);
    expect_out("R9 swap no-excl", 1, 1, BLK, 1, 0);
    chk("R10 fill length", int'(out_len), BLK);
  endtask

  task automatic t_illegal();
    apply(0, 1'b0, 1'b1, 2, 4);
    expect_out("R7 writable excl", 0, 0, 0, 0, 1);
    apply(0, 1'b0, 1'b0, 1, 4);
    expect_out("R7 shared no-excl", 0, 0, 0, 0, 1);
    apply(6, 1'b0, 1'b0, 0, 4);
    expect_out("R11 kind 6", 0, 0, 0, 0, 1);
    apply(7, 1'b1, 1'b1, 0, 4);
    expect_out("R11 kind 7", 0, 0, 0, 0, 1);
    apply(0, 1'b0, 1'b0, 3, 4);
    expect_out("R11 state 3 R12", 0, 0, 0, 0, 1);
  endtask

  task automatic t_hold();
    apply(0, 1'b0, 1'b0, 0, 4);
    @(negedge clk);
    chk("R2 valid drops", int'(out_valid), 0);
    chk("R2 cmd held", int'(out_cmd), 1);
    in_kind = 3'd7; in_state = 2'd3;
    @(negedge clk);
    chk("R2 idle ignores inputs", int'(out_err), 0);
    chk("R2 idle cmd", int'(out_cmd), 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_reset();
        t_uncache();
        t_bypass();
        t_upgrade();
        t_fills();
        t_illegal();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule